// File: doc/BRIEF.md
# Triple-Buffered Tile Store

This block holds three physical copies of an output tile and shares them among a three-stage coarse-grain pipeline. Stage 1 fills a tile from memory. Stage 2 reads each word back, adds a partial result and writes it again. Stage 3 reads the finished tile out to memory. Each stage has its own word port, made of a write enable, an address, write data and read data. The block steers every port to the physical copy that holds that stage's current iteration. As a result, a tile written in one period is found by the next stage in the next period, and no value slips into another iteration. The tile contents and the arithmetic belong to the stages, not to this block.

A head pointer counts pipeline periods modulo three. Stage s (numbered 0, 1 and 2 for the load, accumulate and store stages) uses copy (head - s) mod 3. The sequencer reports each stage's completion with a one-cycle `stage_done` pulse. It presents `iter_in` while a new iteration is waiting to enter the load stage. The period ends with a single-cycle `advance` once every occupied stage has finished. At that point the occupancy flags shift one place toward the store stage, and `iter_in` enters at the load stage. Empty slots during fill, drain and bubbles count as finished, and they cannot write. The ports are plain control and memory pins with no valid/ready handshake. A stage must not present a write in a cycle where it has no work.

Top module: `tile_tribuf`

## Requirements
- R1: After reset, `stage_valid` is 000, `advance` is 0, and `stage_buf` is 6'b01_10_00. Each stage's 2-bit copy index sits at bits [2s+1:2s], so the load stage uses copy 0, the accumulate stage copy 2 and the store stage copy 1.
- R2: At all times `stage_buf` for stage s equals (a - s) mod 3, where a is the number of `advance` cycles since reset. The three indices are always distinct.
- R3: `advance` is high in a cycle exactly when two conditions hold together. First, every stage whose `stage_valid` bit is set has pulsed `stage_done` in that cycle or since the previous advance. Second, either some `stage_valid` bit is set or `iter_in` is high. Head and flags change only on an advance.
- R4: On an advance, `stage_valid` becomes {old bit 1, old bit 0, `iter_in`}. Bit 0 is the load stage and bit 2 is the store stage.
- R5: A `stage_done` pulse from a stage whose valid bit is clear has no effect. Completions recorded in one period are forgotten at the advance, so the next period waits for fresh pulses.
- R6: A word written through stage s's port lands in copy `stage_buf[s]`. After one advance, the same word reads back through stage s+1's port, so data written by the load stage, then accumulated, reaches the store stage intact.
- R7: A write presented by a stage whose valid bit is clear changes no copy.
- R8: Read data appears on `rdata` one cycle after the address. It comes from the copy mapped to that stage in the cycle the address was presented, even if an advance falls between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iter_in | input | 1 | A new iteration is ready to enter the load stage |
| stage_done | input | 3 | One-cycle completion pulse per stage (bit 0 load, bit 2 store) |
| advance | output | 1 | Pipeline period ends this cycle |
| stage_valid | output | 3 | Stage holds a live iteration |
| stage_buf | output | 6 | Physical copy index per stage, 2 bits each |
| wr_en | input | 3 | Per-stage write enable |
| addr | input | 3*AW | Per-stage word address, AW bits each |
| wdata | input | 3*DW | Per-stage write data, DW bits each |
| rdata | output | 3*DW | Per-stage read data, one cycle after address |

## Verification
The bench runs a stream of iterations through a 4-word, 8-bit configuration. The stream has back-to-back entries, a bubble, an idle gap with nothing in flight, and a full drain followed by a restart. This tells correct fill and drain skipping apart from rotation that ignores occupancy. The order of completions is varied across periods: one chosen stage finishes last, some stages finish early, and in some periods all stages finish in the same cycle. Stray pulses from empty stages are added. Together these separate a true all-finished gate from one that fires on the first or last pulse, or keeps stale completions. Stores from empty stages, and a read issued in the very cycle of an advance, show whether writes are gated and whether read data follows the copy mapped at the time of the address.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;
  localparam int NSTG = 3;
  typedef logic [1:0] bsel_t;

  function automatic bsel_t ring_back(input bsel_t h, input int unsigned s);
    int unsigned t;
    t = (32'(h) + NSTG - s) % NSTG;
    return bsel_t'(t);
  endfunction
endpackage

// File: rtl/tribuf_ctrl.sv
module tribuf_ctrl
  import tribuf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iter_in,
  input  logic [NSTG-1:0] stage_done,
  output bsel_t           head,
  output logic [NSTG-1:0] valid,
  output logic            adv
);
  logic [NSTG-1:0] done_q;
  logic [NSTG-1:0] ready;

  assign ready = ~valid | done_q | stage_done;
  assign adv   = (&ready) && ((|valid) || iter_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      valid  <= '0;
      done_q <= '0;
    end else if (adv) begin
      head   <= (head == bsel_t'(NSTG - 1)) ? '0 : head + 1'b1;
      valid  <= {valid[NSTG-2:0], iter_in};
      done_q <= '0;
    end else begin
      done_q <= done_q | (stage_done & valid);
    end
  end

  // R4
  shift_on_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (valid[NSTG-1:1] == $past(valid[NSTG-2:0])) && (valid[0] == $past(iter_in)));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(valid) && $stable(head));

  // R5
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q & ~valid) == '0);

  // R2
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head < bsel_t'(NSTG));
endmodule

// File: rtl/tribuf_map.sv
module tribuf_map
  import tribuf_pkg::*;
(
  input  bsel_t                head,
  output logic [NSTG-1:0][1:0] sel
);
  for (genvar s = 0; s < NSTG; s++) begin : g_sel
    assign sel[s] = ring_back(head, s);
  end
endmodule

// File: rtl/tribuf_bank.sv
module tribuf_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/tile_tribuf.sv
module tile_tribuf
  import tribuf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iter_in,
  input  logic [NSTG-1:0]    stage_done,
  output logic               advance,
  output logic [NSTG-1:0]    stage_valid,
  output logic [2*NSTG-1:0]  stage_buf,
  input  logic [NSTG-1:0]    wr_en,
  input  logic [NSTG*AW-1:0] addr,
  input  logic [NSTG*DW-1:0] wdata,
  output logic [NSTG*DW-1:0] rdata
);
  bsel_t                 head;
  logic [NSTG-1:0]       valid;
  logic                  adv;
  logic [NSTG-1:0][1:0]  sel;
  logic [NSTG-1:0][1:0]  rsel_q;
  logic [NSTG-1:0][DW-1:0] bank_rd;
  logic [NSTG-1:0]       bank_we;

  tribuf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .iter_in(iter_in), .stage_done(stage_done),
    .head(head), .valid(valid), .adv(adv)
  );

  tribuf_map u_map (.head(head), .sel(sel));

  assign advance     = adv;
  assign stage_valid = valid;

  for (genvar b = 0; b < NSTG; b++) begin : g_bank
    logic [AW-1:0] a_b;
    logic [DW-1:0] d_b;
    always_comb begin
      bank_we[b] = 1'b0;
      a_b        = '0;
      d_b        = '0;
      for (int s = 0; s < NSTG; s++) begin
        if (sel[s] == 2'(b)) begin
          bank_we[b] = wr_en[s] & valid[s];
          a_b        = addr[s*AW +: AW];
          d_b        = wdata[s*DW +: DW];
        end
      end
    end
    tribuf_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .we(bank_we[b]), .addr(a_b), .wdata(d_b), .rdata(bank_rd[b])
    );
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_port
    assign stage_buf[2*s +: 2] = sel[s];
    assign rdata[s*DW +: DW]   = bank_rd[rsel_q[s]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsel_q <= '0;
    else        rsel_q <= sel;
  end

  // R2
  distinct_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[0] != sel[1]) && (sel[1] != sel[2]) && (sel[0] != sel[2]));

  // R6
  copy_follows_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (sel[1] == $past(sel[0])) && (sel[2] == $past(sel[1])));

  // R7
  idle_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en & valid) == '0) |-> (bank_we == '0));
endmodule

// File: tb/tile_tribuf_test.sv
`timescale 1ns/1ps
module tile_tribuf_test;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int AW = 2;
  localparam int NP = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iter_in = 1'b0;
  logic [2:0] stage_done = '0;
  logic advance;
  logic [2:0] stage_valid;
  logic [5:0] stage_buf;
  logic [2:0] wr_en = '0;
  logic [3*AW-1:0] addr = '0;
  logic [3*DW-1:0] wdata = '0;
  logic [3*DW-1:0] rdata;

  always #2.5 clk = ~clk;

  tile_tribuf #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .iter_in(iter_in), .stage_done(stage_done),
    .advance(advance), .stage_valid(stage_valid), .stage_buf(stage_buf),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int m_head = 0;
  logic [2:0] m_valid = '0;
  int m_id [3];
  int next_id = 0;
  logic [DW-1:0] exp_mem [3][DEPTH];
  bit known [3];
  bit it_pat [NP] = '{1,1,0,1,1,1,1,1,0,0,0,0,1,1,0,0,0,0};

  function automatic int mbuf(input int s);
    return (m_head + 3 - s) % 3;
  endfunction
  function automatic logic [DW-1:0] f_ld(input int id, input int a);
    return DW'(id * 16 + a * 3 + 5);
  endfunction
  function automatic logic [DW-1:0] g_acc(input int id);
    return DW'(id + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int s, input bit we, input int a, input logic [DW-1:0] d);
    wr_en[s] = we;
    addr[s*AW +: AW] = AW'(a);
    wdata[s*DW +: DW] = d;
  endtask

  task automatic chk_map(input string req);
    int exp;
    exp = (mbuf(2) << 4) | (mbuf(1) << 2) | mbuf(0);
    chk(stage_buf == 6'(exp), req, int'(stage_buf), exp);
    chk(stage_valid == m_valid, "R4 stage_valid", int'(stage_valid), int'(m_valid));
  endtask

  task automatic read_chk(input int s, input int a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    drive(s, 1'b0, a, '0);
    @(negedge clk);
    chk(rdata[s*DW +: DW] == exp, req, int'(rdata[s*DW +: DW]), int'(exp));
  endtask

  task automatic run_period(input int p);
    int last;
    int oldb2;
    bit k2;
    chk_map("R2 stage_buf");
    // load stage
    if (m_valid[0]) begin
      for (int a = 0; a < DEPTH; a++) begin
        @(negedge clk);
        drive(0, 1'b1, a, f_ld(m_id[0], a));
        exp_mem[mbuf(0)][a] = f_ld(m_id[0], a);
      end
      known[mbuf(0)] = 1;
      @(negedge clk);
      drive(0, 1'b0, 0, '0);
    end
    // accumulate stage
    if (m_valid[1]) begin
      for (int a = 0; a < DEPTH; a++) begin
        logic [DW-1:0] v;
        @(negedge clk);
        drive(1, 1'b0, a, '0);
        @(negedge clk);
        v = rdata[DW +: DW];
        chk(v == exp_mem[mbuf(1)][a], "R6 accumulate read", int'(v), int'(exp_mem[mbuf(1)][a]));
        drive(1, 1'b1, a, v + g_acc(m_id[1]));
        exp_mem[mbuf(1)][a] = v + g_acc(m_id[1]);
      end
      @(negedge clk);
      drive(1, 1'b0, 0, '0);
    end
    // store stage
    if (m_valid[2]) begin
      for (int a = 0; a < DEPTH; a++)
        read_chk(2, a, f_ld(m_id[2], a) + g_acc(m_id[2]), "R6 store read");
    end
    // empty stages try to write
    for (int s = 0; s < 3; s++) begin
      if (!m_valid[s] && known[mbuf(s)]) begin
        @(negedge clk);
        drive(s, 1'b1, 1, 8'hEE);
        @(negedge clk);
        drive(s, 1'b0, 1, '0);
        @(negedge clk);
        chk(rdata[s*DW +: DW] == exp_mem[mbuf(s)][1], "R7 blocked write",
            int'(rdata[s*DW +: DW]), int'(exp_mem[mbuf(s)][1]));
      end
    end
    // completion phase
    @(negedge clk);
    iter_in = it_pat[p];
    if (m_valid == 3'b000) begin
      #1;
      chk(advance == it_pat[p], "R3 empty pipe", int'(advance), int'(it_pat[p]));
      if (!it_pat[p]) begin
        iter_in = 1'b0;
        return;
      end
    end else begin
      last = p % 3;
      if (!m_valid[last]) last = m_valid[2] ? 2 : (m_valid[1] ? 1 : 0);
      if (p % 4 != 3) begin
        for (int s = 0; s < 3; s++) begin
          if (s != last) begin
            stage_done = 3'b001 << s;
            #1;
            chk(advance == 1'b0, "R3 partial done", int'(advance), 0);
            @(negedge clk);
          end
        end
        stage_done = ~m_valid;
        #1;
        chk(advance == 1'b0, "R5 stray done", int'(advance), 0);
        @(negedge clk);
        stage_done = 3'b001 << last;
      end else begin
        stage_done = 3'b111;
      end
      drive(2, 1'b0, 0, '0);
      #1;
      chk(advance == 1'b1, "R3 final done", int'(advance), 1);
    end
    oldb2 = mbuf(2);
    k2 = known[oldb2];
    drive(2, 1'b0, 0, '0);
    @(negedge clk);
    stage_done = '0;
    iter_in = 1'b0;
    if (k2) chk(rdata[2*DW +: DW] == exp_mem[oldb2][0], "R8 read across advance",
                int'(rdata[2*DW +: DW]), int'(exp_mem[oldb2][0]));
    m_head = (m_head + 1) % 3;
    m_valid = {m_valid[1:0], it_pat[p]};
    m_id[2] = m_id[1];
    m_id[1] = m_id[0];
    m_id[0] = next_id;
    if (it_pat[p]) next_id++;
    #1;
    chk(advance == 1'b0, "R5 done cleared", int'(advance), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 3; b++) known[b] = 0;
    for (int s = 0; s < 3; s++) m_id[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(stage_valid == 3'b000, "R1 valid", int'(stage_valid), 0);
    chk(stage_buf == 6'b01_10_00, "R1 stage_buf", int'(stage_buf), 6'b01_10_00);
    chk(advance == 1'b0, "R1 advance", int'(advance), 0);
    stage_done = 3'b111;
    #1;
    chk(advance == 1'b0, "R5 done when empty", int'(advance), 0);
    @(negedge clk);
    stage_done = '0;
    chk(stage_buf == 6'b01_10_00, "R3 no advance", int'(stage_buf), 6'b01_10_00);
    for (int p = 0; p < NP; p++) run_period(p);
    chk_map("R2 final map");
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule